// File: doc/BRIEF.md
# Three-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter that advances on one of two sources: an internal tick produced every twelve clock cycles, or falling edges seen on an external count pin. A single 8-bit control register picks how the counter behaves when it passes its all-ones value. In capture mode it wraps to zero. In reload mode it reloads from a 16-bit holding register. In baud mode it reloads in the same way and also emits tick pulses that a serial port uses as its receive and/or transmit bit clock.

A second external pin, the trigger, can latch the running count into the holding register (capture mode) or force an immediate reload (reload mode). Two sticky flags, one for overflow and one for trigger events, are set by hardware and cleared only by software. Their OR forms an interrupt request. Software reaches the control register, both count bytes and both holding bytes through a small byte-wide register port with registered read data.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset the control, count and holding registers read 0x00, and `irq`, `rx_tick` and `tx_tick` are low.
- R2: Register addresses are: 0 = control, 1 = count low byte, 2 = count high byte, 3 = holding low byte, 4 = holding high byte. Any other address reads 0x00. `reg_rdata` shows the addressed register as it stood before the clock edge that follows the address, and it is valid after that edge.
- R3: With control bit 2 (run) = 1 and bit 1 (source) = 0, the count rises by one every 12 clock cycles. The first increment lands 12 cycles after the edge that wrote run = 1.
- R4: With source = 1 and run = 1, each falling edge on `cnt_pin` adds one. The count register changes on the third rising clock edge after the pin falls.
- R5: With run = 0 the count never advances, in any mode.
- R6: Capture mode is control bit 0 = 1 with bits 5 and 4 both 0. In this mode an increment from 0xFFFF gives 0x0000 and sets control bit 7 (overflow flag).
- R7: In capture mode with bit 3 (trigger enable) = 1, a falling edge on `trig_pin` copies the count into the holding register and sets control bit 6 (trigger flag).
- R8: Reload mode is bit 0 = 0 with bits 5 and 4 both 0. In this mode an increment from 0xFFFF loads the holding value and sets bit 7. With bit 3 = 1, a falling trigger edge also loads the holding value and sets bit 6.
- R9: If bit 5 or bit 4 is 1 (baud mode), an overflow reloads from the holding register whatever bit 0 holds. Bit 7 is never set by hardware in this mode, and the trigger pin is ignored.
- R10: `rx_tick` is a one-cycle pulse in the cycle after a baud-mode overflow edge when bit 5 = 1; otherwise it follows `t1_ovf` one cycle late. `tx_tick` behaves the same way under bit 4.
- R11: With bit 3 = 0, trigger edges change neither the holding register, the count nor bit 6.
- R12: Bits 7 and 6 stay set until software writes them to 0. A hardware set in the same cycle as a clearing write wins.
- R13: `irq` is high exactly when bit 7 or bit 6 is set.
- R14: A software write to a count byte takes priority over an increment or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input, falling-edge active |
| trig_pin | input | 1 | External capture/reload trigger, falling-edge active |
| t1_ovf | input | 1 | Alternate baud tick from another timer |
| rx_tick | output | 1 | Receive bit-clock tick |
| tx_tick | output | 1 | Transmit bit-clock tick |
| irq | output | 1 | Interrupt request, OR of the two flags |

## Verification
A pin edge passes through the synchronizer and the edge comparator before it reaches the counter. The count therefore changes on the third rising edge after the pin falls, and a register read shows it one edge later. The bench samples at the falling clock edge, confirms the old value on the third edge and the new one on the fourth, and waits four cycles after every pin event before it reads anything back. The internal tick is checked at 59 and 60 cycles after the run write, which pins the 12-cycle period. The baud tick is checked to be low one cycle before the overflow edge, high just after it, and low again one cycle later. For the alternate tick input, the bench looks for an output pulse exactly one cycle after it drives `t1_ovf`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic ovf;      // bit 7: overflow flag
    logic ext;      // bit 6: trigger flag
    logic rx_sel;   // bit 5: receive tick from this timer
    logic tx_sel;   // bit 4: transmit tick from this timer
    logic ext_en;   // bit 3: trigger enable
    logic run;      // bit 2: run
    logic ct_sel;   // bit 1: 1 = count pin edges, 0 = internal tick
    logic cap_sel;  // bit 0: 1 = capture, 0 = reload
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_CAPTURE,
    MODE_RELOAD,
    MODE_BAUD
  } mode_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  // stages [SYNC_STAGES-1:0] synchronize, the extra stage holds the previous sample
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], pin};
  end

  assign fall = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];

  // R4: one pin edge yields exactly one single-cycle event
  assert_single_fall_R4: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run)        phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + PW'(1);
  end

  assign tick = run && (phase_q == LAST);

  // R3: ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R5: a stopped timer gives no tick in the next cycle
  assert_stopped_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              tick_int,
  input  logic              fall_cnt,
  input  logic              fall_trig,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              baud_ovf
);
  localparam int NBYTE = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;

  logic             ctrl_we;
  logic [NBYTE-1:0] cnt_bwe;
  logic [NBYTE-1:0] cap_bwe;
  logic             cnt_we;

  assign ctrl_we = we && (addr == A_CTRL);

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign cnt_bwe[g] = we && (addr == ADDR_W'(1 + g));
    assign cap_bwe[g] = we && (addr == ADDR_W'(1 + NBYTE + g));
  end

  assign cnt_we = |cnt_bwe;

  logic  baud_sel, inc_en, wrap, ext_ok, ext_reload, ext_capture;
  mode_e mode;

  always_comb begin
    baud_sel = ctrl_q.rx_sel | ctrl_q.tx_sel;
    if (!ctrl_q.run)         mode = MODE_OFF;
    else if (baud_sel)       mode = MODE_BAUD;
    else if (ctrl_q.cap_sel) mode = MODE_CAPTURE;
    else                     mode = MODE_RELOAD;
    inc_en      = (mode != MODE_OFF) && (ctrl_q.ct_sel ? fall_cnt : tick_int);
    wrap        = inc_en && (cnt_q == {CNT_W{1'b1}});
    ext_ok      = ctrl_q.ext_en && !baud_sel && fall_trig;
    ext_reload  = ext_ok && !ctrl_q.cap_sel;
    ext_capture = ext_ok && ctrl_q.cap_sel;
  end

  logic [CNT_W-1:0] cnt_d, cap_d;
  ctrl_t            ctrl_d;

  always_comb begin
    // count: software byte write > trigger reload > increment/wrap
    cnt_d = cnt_q;
    if (wrap)        cnt_d = (mode == MODE_CAPTURE) ? '0 : cap_q;
    else if (inc_en) cnt_d = cnt_q + CNT_W'(1);
    if (ext_reload)  cnt_d = cap_q;
    for (int i = 0; i < NBYTE; i++)
      if (cnt_bwe[i]) cnt_d[8*i +: 8] = wdata;

    // holding register: hardware capture wins over a software byte write
    cap_d = cap_q;
    for (int i = 0; i < NBYTE; i++)
      if (cap_bwe[i]) cap_d[8*i +: 8] = wdata;
    if (ext_capture) cap_d = cnt_q;

    // control: hardware flag set wins over a clearing write
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wdata);
    if (wrap && !baud_sel) ctrl_d.ovf = 1'b1;
    if (ext_ok)            ctrl_d.ext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      ctrl_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign baud_ovf = wrap && (mode == MODE_BAUD);

  // R6: capture-mode overflow wraps to zero
  assert_capture_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE && wrap && !cnt_we) |=> (cnt_q == '0));
  // R5: a stopped counter holds unless written or reloaded by trigger
  assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !cnt_we && !ext_reload) |=> $stable(cnt_q));
  // R9: no overflow flag from hardware in baud mode
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (baud_sel && !ctrl_q.ovf && !(ctrl_we && wdata[7])) |=> !ctrl_q.ovf);
  // R11: trigger flag untouched while triggers are disabled
  assert_trigger_masked_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.ext_en && !ctrl_q.ext && !(ctrl_we && wdata[6])) |=> !ctrl_q.ext);
  // R8: a trigger reload loads the holding value
  assert_trigger_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_reload && !cnt_we) |=> (cnt_q == $past(cap_q)));
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              t1_ovf,
  output logic              rx_tick,
  output logic              tx_tick,
  output logic              irq
);
  localparam int NBYTE = CNT_W / 8;

  logic             fall_cnt, fall_trig, tick_int, baud_ovf;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, cap_q;

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(fall_cnt));

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(fall_trig));

  tmr_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick_int));

  tmr_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .tick_int(tick_int), .fall_cnt(fall_cnt), .fall_trig(fall_trig),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q), .cap_q(cap_q), .baud_ovf(baud_ovf));

  logic [7:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == '0) rd_mux = ctrl_q;
    for (int i = 0; i < NBYTE; i++) begin
      if (reg_addr == ADDR_W'(1 + i))         rd_mux = cnt_q[8*i +: 8];
      if (reg_addr == ADDR_W'(1 + NBYTE + i)) rd_mux = cap_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      rx_tick   <= 1'b0;
      tx_tick   <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      rx_tick   <= ctrl_q.rx_sel ? baud_ovf : t1_ovf;
      tx_tick   <= ctrl_q.tx_sel ? baud_ovf : t1_ovf;
    end
  end

  assign irq = ctrl_q.ovf | ctrl_q.ext;

  // R10: without the receive select, the receive tick tracks the alternate source
  assert_rx_alt_source_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.rx_sel |=> (rx_tick == $past(t1_ovf)));
  // R10: without the transmit select, the transmit tick tracks the alternate source
  assert_tx_alt_source_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.tx_sel |=> (tx_tick == $past(t1_ovf)));
endmodule

// File: tb/tri_mode_timer_test.sv
`timescale 1ns/1ps
module tri_mode_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       t1_ovf = 1'b0;
  logic       rx_tick, tx_tick, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tri_mode_timer uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .t1_ovf(t1_ovf), .rx_tick(rx_tick),
    .tx_tick(tx_tick), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic cnt_fall;
    @(negedge clk); cnt_pin = 1'b0;
    repeat (4) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic trig_fall;
    @(negedge clk); trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rdata after reset", reg_rdata, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 rx_tick", rx_tick, 0);
    chk("R1 tx_tick", tx_tick, 0);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    wr(3, 8'hA5); wr(4, 8'h5A);
    rd(3, v); chk("R2 holding low", v, 8'hA5);
    rd(4, v); chk("R2 holding high", v, 8'h5A);
    rd(7, v); chk("R2 unmapped address", v, 0);
  endtask

  task automatic t_internal;
    logic [7:0] v;
    wr(0, 8'h04);
    repeat (59) @(negedge clk);
    rd(1, v); chk("R3 count before 5th tick", v, 4);
    rd(1, v); chk("R3 count after 5th tick", v, 5);
    wr(0, 8'h00);
  endtask

  task automatic t_external;
    logic [7:0] v;
    wr(1, 0); wr(2, 0); wr(0, 8'h06);
    @(negedge clk); cnt_pin = 1'b0; reg_addr = 1;
    repeat (3) @(negedge clk);
    chk("R4 no count by 3rd edge read", reg_rdata, 0);
    @(negedge clk);
    chk("R4 count seen at 4th edge read", reg_rdata, 1);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    cnt_fall; cnt_fall;
    rd(1, v); chk("R4 three edges counted", v, 3);
    // R14: write lands on the same edge as an increment
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = 1; reg_wdata = 8'h55;
    @(negedge clk); reg_we = 1'b0; cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, v); chk("R14 write beats increment", v, 8'h55);
    rd(2, v); chk("R14 high byte untouched", v, 0);
    // R5: stopped timer ignores count edges
    wr(0, 8'h02);
    cnt_fall; cnt_fall;
    rd(1, v); chk("R5 stopped count holds", v, 8'h55);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    wr(0, 0); wr(1, 8'h03); wr(2, 8'h02); wr(0, 8'h0F);
    trig_fall;
    rd(3, v); chk("R7 captured low", v, 8'h03);
    rd(4, v); chk("R7 captured high", v, 8'h02);
    rd(0, v); chk("R7 trigger flag set", v, 8'h4F);
    chk("R13 irq from trigger flag", irq, 1);
    repeat (20) @(negedge clk);
    rd(0, v); chk("R12 flag persists", v, 8'h4F);
    wr(0, 8'h0F);
    rd(0, v); chk("R12 flag cleared by write", v, 8'h0F);
    chk("R13 irq low with flags clear", irq, 0);
    // R11: triggers disabled
    wr(0, 8'h07); wr(1, 8'h99);
    trig_fall;
    rd(3, v); chk("R11 holding unchanged", v, 8'h03);
    rd(0, v); chk("R11 trigger flag stays clear", v, 8'h07);
    // R6: capture-mode overflow
    wr(1, 8'hFF); wr(2, 8'hFF);
    cnt_fall;
    rd(1, v); chk("R6 wrap low", v, 0);
    rd(2, v); chk("R6 wrap high", v, 0);
    rd(0, v); chk("R6 overflow flag", v, 8'h87);
    chk("R13 irq from overflow flag", irq, 1);
  endtask

  task automatic t_reload;
    logic [7:0] v;
    wr(0, 0); wr(3, 8'h34); wr(4, 8'h12); wr(1, 8'hFF); wr(2, 8'hFF);
    wr(0, 8'h06);
    cnt_fall;
    rd(1, v); chk("R8 overflow reload low", v, 8'h34);
    rd(2, v); chk("R8 overflow reload high", v, 8'h12);
    rd(0, v); chk("R8 overflow flag", v, 8'h86);
    wr(0, 8'h0E); wr(1, 8'h10); wr(2, 8'h00);
    trig_fall;
    rd(1, v); chk("R8 trigger reload low", v, 8'h34);
    rd(2, v); chk("R8 trigger reload high", v, 8'h12);
    rd(0, v); chk("R8 trigger flag", v, 8'h4E);
  endtask

  task automatic t_baud;
    logic [7:0] v;
    wr(0, 0); wr(3, 8'h00); wr(4, 8'h80); wr(1, 8'hFF); wr(2, 8'hFF);
    wr(0, 8'h2F);
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R10 rx_tick before overflow", rx_tick, 0);
    @(negedge clk); chk("R10 rx_tick on overflow", rx_tick, 1);
    chk("R10 tx_tick not selected", tx_tick, 0);
    @(negedge clk); chk("R10 rx_tick single cycle", rx_tick, 0);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, v); chk("R9 baud reload low", v, 8'h00);
    rd(2, v); chk("R9 baud reload high", v, 8'h80);
    rd(0, v); chk("R9 no overflow flag", v, 8'h2F);
    trig_fall;
    rd(0, v); chk("R9 trigger ignored flag", v, 8'h2F);
    rd(2, v); chk("R9 trigger ignored count", v, 8'h80);
    @(negedge clk); t1_ovf = 1'b1;
    @(negedge clk); t1_ovf = 1'b0;
    chk("R10 tx_tick from alternate", tx_tick, 1);
    chk("R10 rx_tick ignores alternate", rx_tick, 0);
    @(negedge clk); chk("R10 tx_tick single cycle", tx_tick, 0);
    wr(0, 0);
    @(negedge clk); t1_ovf = 1'b1;
    @(negedge clk); t1_ovf = 1'b0;
    chk("R10 rx_tick from alternate", rx_tick, 1);
    chk("R10 tx_tick from alternate again", tx_tick, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_internal;
    t_external;
    t_capture;
    t_reload;
    t_baud;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule